// File: doc/BRIEF.md
# Display Command Sequence Player

This block drives a small monochrome LCD controller over a write-only serial link. It plays fixed scripts held in an internal script ROM. Each script entry is either a raw command byte or a control escape. An escape sets the chip-select level, sets the command/data select level, pulses the active-low reset line for a number of milliseconds, waits a number of milliseconds, or ends the script. Command bytes go out through the included serial shifter, most significant bit first.

There are four request inputs: power-up init, wake, sleep and contrast set. A contrast request carries an 8-bit value. The matching script produces the extended-set command 0x21 followed by 0x80 OR'd with the value shifted right by one. Millisecond timing is derived from the `CLK_HZ` parameter. The serial clock half-period `SCK_HALF` (in clocks) defaults to the smallest value that keeps the serial period at 400 ns or longer.

A one-cycle `done_o` pulse marks the end of a script. `busy_o` covers the whole run, and requests that arrive during a run are dropped.

Top module: `lcdseq_player`

## Requirements
- R1: After reset, busy_o=0, done_o=0, lcd_csn_o=1, lcd_rstn_o=1, lcd_dc_o=0 and lcd_sclk_o=0.
- R2: The init script sends, in this order, 0x21, 0x06, 0x13, 0xC0, 0x20, 0x0C, 0x20, 0x0D, 0x20, 0x0C. Every byte is sent with lcd_dc_o=0 (command) and lcd_csn_o=0.
- R3: Init first sets lcd_csn_o=1 and lcd_dc_o=0. It then holds lcd_rstn_o low for 18 ms (18*CLK_HZ/1000 clocks, plus at most 2) while lcd_csn_o stays high, and only then selects the chip.
- R4: Init waits at least 100 ms after the first 0x0C and at least 200 ms after 0x0D. It also waits at least 100 ms after the final 0x0C before the script ends.
- R5: The wake script sends 0x20 then 0x0C.
- R6: The sleep script sends 0x20, 0x08, 0x24 and then waits at least 50 ms before it ends.
- R7: The contrast script sends 0x21 then (0x80 | contrast_i>>1). contrast_i is sampled with the request.
- R8: lcd_sclk_o idles low. Bits go out MSB first, and lcd_mosi_o is stable while lcd_sclk_o is high, so the receiver can sample on the rising edge. Each high phase and each low phase lasts SCK_HALF clocks.
- R9: busy_o rises the cycle after an accepted request and stays high until the end entry. done_o is a one-cycle pulse in the first cycle with busy_o low. lcd_csn_o is 1 once every script has ended.
- R10: Requests that arrive while busy_o is high are ignored, and the running script's byte stream is unchanged.
- R11: When several requests arrive in the same cycle, only one runs, in the priority order init, sleep, wake, contrast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_req_i | input | 1 | Start power-up init script |
| wake_req_i | input | 1 | Start wake script |
| sleep_req_i | input | 1 | Start sleep script |
| contrast_req_i | input | 1 | Start contrast script |
| contrast_i | input | 8 | Contrast value sampled with contrast_req_i |
| busy_o | output | 1 | A script is running |
| done_o | output | 1 | One-cycle end-of-script pulse |
| lcd_csn_o | output | 1 | Display chip-select, active low |
| lcd_dc_o | output | 1 | Command (0) / data (1) select |
| lcd_rstn_o | output | 1 | Display reset, active low |
| lcd_sclk_o | output | 1 | Serial clock |
| lcd_mosi_o | output | 1 | Serial data |

## Verification
The byte stream is captured on rising serial-clock edges and compared against four scripts. The contrast script is run with values 0x00, 0xFF and 0x5A, which tells a correct shift-and-OR apart from a missing shift, a wrong fill bit or a dropped low bit. Time stamps on the captured bytes separate the 50, 100 and 200 ms waits from each other and from the 18 ms reset pulse, so a swapped or missing delay shows up. Overlapping and simultaneous requests check that a running script is not disturbed and that the priority order is kept.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    typedef enum logic [2:0] {
        K_CMD, K_CS, K_DC, K_RST, K_DLY, K_END
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] arg;
    } entry_t;

    typedef enum logic [1:0] {
        SC_INIT, SC_WAKE, SC_SLEEP, SC_CONTRAST
    } script_e;

    typedef enum logic [1:0] {
        P_IDLE, P_FETCH, P_SEND, P_WAIT
    } pstate_e;

    localparam int IDX_W = 5;

    function automatic entry_t mk(kind_e k, logic [7:0] a);
        entry_t e;
        e.kind = k;
        e.arg  = a;
        return e;
    endfunction

endpackage

// File: rtl/lcdseq_rom.sv
module lcdseq_rom
    import lcdseq_pkg::*;
(
    input  script_e              script_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [7:1]           contrast_i,
    output entry_t               entry_o
);

    always_comb begin
        entry_o = mk(K_END, 8'h00);
        unique case (script_i)
            SC_INIT: begin
                case (idx_i)
                    5'd0:  entry_o = mk(K_CS,  8'd0);
                    5'd1:  entry_o = mk(K_DC,  8'd0);
                    5'd2:  entry_o = mk(K_RST, 8'd18);
                    5'd3:  entry_o = mk(K_CS,  8'd1);
                    5'd4:  entry_o = mk(K_CMD, 8'h21);
                    5'd5:  entry_o = mk(K_CMD, 8'h06);
                    5'd6:  entry_o = mk(K_CMD, 8'h13);
                    5'd7:  entry_o = mk(K_CMD, 8'hC0);
                    5'd8:  entry_o = mk(K_CMD, 8'h20);
                    5'd9:  entry_o = mk(K_CMD, 8'h0C);
                    5'd10: entry_o = mk(K_DLY, 8'd100);
                    5'd11: entry_o = mk(K_CMD, 8'h20);
                    5'd12: entry_o = mk(K_CMD, 8'h0D);
                    5'd13: entry_o = mk(K_DLY, 8'd200);
                    5'd14: entry_o = mk(K_CMD, 8'h20);
                    5'd15: entry_o = mk(K_CMD, 8'h0C);
                    5'd16: entry_o = mk(K_DLY, 8'd100);
                    5'd17: entry_o = mk(K_CS,  8'd0);
                    default: entry_o = mk(K_END, 8'h00);
                endcase
            end
            SC_WAKE: begin
                case (idx_i)
                    5'd0:  entry_o = mk(K_DC,  8'd0);
                    5'd1:  entry_o = mk(K_CS,  8'd1);
                    5'd2:  entry_o = mk(K_CMD, 8'h20);
                    5'd3:  entry_o = mk(K_CMD, 8'h0C);
                    5'd4:  entry_o = mk(K_CS,  8'd0);
                    default: entry_o = mk(K_END, 8'h00);
                endcase
            end
            SC_SLEEP: begin
                case (idx_i)
                    5'd0:  entry_o = mk(K_DC,  8'd0);
                    5'd1:  entry_o = mk(K_CS,  8'd1);
                    5'd2:  entry_o = mk(K_CMD, 8'h20);
                    5'd3:  entry_o = mk(K_CMD, 8'h08);
                    5'd4:  entry_o = mk(K_CMD, 8'h24);
                    5'd5:  entry_o = mk(K_DLY, 8'd50);
                    5'd6:  entry_o = mk(K_CS,  8'd0);
                    default: entry_o = mk(K_END, 8'h00);
                endcase
            end
            default: begin
                case (idx_i)
                    5'd0:  entry_o = mk(K_DC,  8'd0);
                    5'd1:  entry_o = mk(K_CS,  8'd1);
                    5'd2:  entry_o = mk(K_CMD, 8'h21);
                    5'd3:  entry_o = mk(K_CMD, {1'b1, contrast_i});
                    5'd4:  entry_o = mk(K_CS,  8'd0);
                    default: entry_o = mk(K_END, 8'h00);
                endcase
            end
        endcase
    end

endmodule

// File: rtl/lcdseq_msdelay.sv
module lcdseq_msdelay #(
    parameter int CYC_PER_MS = 1000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic [7:0] ms_i,
    output logic       done_o
);

    localparam int CYC_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_MS - 1);

    typedef struct packed {
        logic             run;
        logic [CYC_W-1:0] cyc;
        logic [7:0]       ms;
        logic             done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        if (load_i) begin
            tmr_d.cyc = '0;
            tmr_d.ms  = ms_i;
            if (ms_i == 8'd0) begin
                tmr_d.run  = 1'b0;
                tmr_d.done = 1'b1;
            end else begin
                tmr_d.run = 1'b1;
            end
        end else if (tmr_q.run) begin
            if (tmr_q.cyc == CYC_LAST) begin
                tmr_d.cyc = '0;
                tmr_d.ms  = tmr_q.ms - 8'd1;
                if (tmr_q.ms == 8'd1) begin
                    tmr_d.run  = 1'b0;
                    tmr_d.done = 1'b1;
                end
            end else begin
                tmr_d.cyc = tmr_q.cyc + CYC_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign done_o = tmr_q.done;

    // R4
    tmr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_q.done |=> !tmr_q.done);

    // R4
    tmr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_q.run |-> (tmr_q.ms != 8'd0));

endmodule

// File: rtl/lcdseq_spi.sv
module lcdseq_spi #(
    parameter int SCK_HALF = 10
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

    typedef struct packed {
        logic             act;
        logic [7:0]       sh;
        logic [2:0]       nbit;
        logic [DIV_W-1:0] div;
        logic             sclk;
        logic             done;
    } spi_t;

    spi_t spi_d, spi_q;

    always_comb begin
        spi_d      = spi_q;
        spi_d.done = 1'b0;
        if (!spi_q.act) begin
            if (start_i) begin
                spi_d.act  = 1'b1;
                spi_d.sh   = byte_i;
                spi_d.nbit = '0;
                spi_d.div  = '0;
                spi_d.sclk = 1'b0;
            end
        end else if (spi_q.div == DIV_LAST) begin
            spi_d.div = '0;
            if (!spi_q.sclk) begin
                spi_d.sclk = 1'b1;
            end else begin
                spi_d.sclk = 1'b0;
                spi_d.sh   = {spi_q.sh[6:0], 1'b0};
                if (spi_q.nbit == 3'd7) begin
                    spi_d.act  = 1'b0;
                    spi_d.done = 1'b1;
                end else begin
                    spi_d.nbit = spi_q.nbit + 3'd1;
                end
            end
        end else begin
            spi_d.div = spi_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) spi_q <= '0;
        else         spi_q <= spi_d;
    end

    assign sclk_o = spi_q.sclk;
    assign mosi_o = spi_q.sh[7];
    assign busy_o = spi_q.act;
    assign done_o = spi_q.done;

    // R8
    sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !spi_q.act |-> !spi_q.sclk);

    // R8
    mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (spi_q.sclk && $past(spi_q.sclk)) |-> $stable(spi_q.sh[7]));

    // R8
    spi_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spi_q.done |-> !spi_q.act);

endmodule

// File: rtl/lcdseq_player.sv
module lcdseq_player
    import lcdseq_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int SCK_HALF = (CLK_HZ + 4_999_999) / 5_000_000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       init_req_i,
    input  logic       wake_req_i,
    input  logic       sleep_req_i,
    input  logic       contrast_req_i,
    input  logic [7:0] contrast_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       lcd_csn_o,
    output logic       lcd_dc_o,
    output logic       lcd_rstn_o,
    output logic       lcd_sclk_o,
    output logic       lcd_mosi_o
);

    localparam int CYC_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

    typedef struct packed {
        pstate_e          state;
        script_e          script;
        logic [IDX_W-1:0] idx;
        logic [7:1]       contrast;
        logic             csn;
        logic             dc;
        logic             rstn;
        logic             done;
    } pl_t;

    pl_t    pl_d, pl_q;
    entry_t ent;
    logic   spi_start, spi_busy, spi_done, tmr_load, tmr_done;

    lcdseq_rom i_rom (
        .script_i   (pl_q.script),
        .idx_i      (pl_q.idx),
        .contrast_i (pl_q.contrast),
        .entry_o    (ent)
    );

    lcdseq_spi #(.SCK_HALF(SCK_HALF)) i_spi (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (spi_start),
        .byte_i  (ent.arg),
        .sclk_o  (lcd_sclk_o),
        .mosi_o  (lcd_mosi_o),
        .busy_o  (spi_busy),
        .done_o  (spi_done)
    );

    lcdseq_msdelay #(.CYC_PER_MS(CYC_PER_MS)) i_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .ms_i   (ent.arg),
        .done_o (tmr_done)
    );

    always_comb begin
        pl_d      = pl_q;
        pl_d.done = 1'b0;
        spi_start = 1'b0;
        tmr_load  = 1'b0;
        unique case (pl_q.state)
            P_IDLE: begin
                if (init_req_i || sleep_req_i || wake_req_i || contrast_req_i) begin
                    pl_d.state = P_FETCH;
                    pl_d.idx   = '0;
                    if (init_req_i)       pl_d.script = SC_INIT;
                    else if (sleep_req_i) pl_d.script = SC_SLEEP;
                    else if (wake_req_i)  pl_d.script = SC_WAKE;
                    else begin
                        pl_d.script   = SC_CONTRAST;
                        pl_d.contrast = contrast_i[7:1];
                    end
                end
            end
            P_FETCH: begin
                pl_d.idx = pl_q.idx + IDX_W'(1);
                unique case (ent.kind)
                    K_CMD: begin
                        spi_start  = 1'b1;
                        pl_d.state = P_SEND;
                    end
                    K_CS: pl_d.csn = ~ent.arg[0];
                    K_DC: pl_d.dc  = ent.arg[0];
                    K_RST: begin
                        pl_d.rstn  = 1'b0;
                        tmr_load   = 1'b1;
                        pl_d.state = P_WAIT;
                    end
                    K_DLY: begin
                        tmr_load   = 1'b1;
                        pl_d.state = P_WAIT;
                    end
                    default: begin
                        pl_d.idx   = pl_q.idx;
                        pl_d.state = P_IDLE;
                        pl_d.done  = 1'b1;
                    end
                endcase
            end
            P_SEND: begin
                if (spi_done) pl_d.state = P_FETCH;
            end
            default: begin
                if (tmr_done) begin
                    pl_d.rstn  = 1'b1;
                    pl_d.state = P_FETCH;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pl_q      <= '0;
            pl_q.csn  <= 1'b1;
            pl_q.rstn <= 1'b1;
        end else begin
            pl_q <= pl_d;
        end
    end

    assign busy_o     = (pl_q.state != P_IDLE);
    assign done_o     = pl_q.done;
    assign lcd_csn_o  = pl_q.csn;
    assign lcd_dc_o   = pl_q.dc;
    assign lcd_rstn_o = pl_q.rstn;

    // R10
    ignore_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (pl_q.script == $past(pl_q.script)));

    // R2
    cs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spi_busy |-> (!lcd_csn_o && !lcd_dc_o));

    // R3
    rst_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lcd_rstn_o |-> (busy_o && lcd_csn_o));

    // R9
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && lcd_csn_o));

endmodule

// File: tb/test_lcdseq_player.sv
module test_lcdseq_player;

    localparam int CLK_HZ   = 20_000;
    localparam int CPM      = CLK_HZ / 1000;
    localparam int SCK_HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_req = 1'b0, wake_req = 1'b0, sleep_req = 1'b0, contrast_req = 1'b0;
    logic [7:0] contrast_v = 8'h00;
    logic busy, done, lcd_csn, lcd_dc, lcd_rstn, lcd_sclk, lcd_mosi;

    always #2 clk = ~clk;

    lcdseq_player #(.CLK_HZ(CLK_HZ), .SCK_HALF(SCK_HALF)) i_lcdseq_player (
        .clk_i(clk), .rst_ni(rst_n),
        .init_req_i(init_req), .wake_req_i(wake_req),
        .sleep_req_i(sleep_req), .contrast_req_i(contrast_req),
        .contrast_i(contrast_v),
        .busy_o(busy), .done_o(done),
        .lcd_csn_o(lcd_csn), .lcd_dc_o(lcd_dc), .lcd_rstn_o(lcd_rstn),
        .lcd_sclk_o(lcd_sclk), .lcd_mosi_o(lcd_mosi)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tfall = 0;

    logic [7:0] cap_b [32];
    logic       cap_dc [32];
    logic       cap_cs [32];
    int         cap_t [32];
    int         ncap = 0;
    int         nb = 0;
    logic [7:0] sh = 8'h00;

    int   rst_low = 0;
    int   rst_low_max = 0;
    logic rst_cs_bad = 1'b0;
    int   hi_cnt = 0;
    int   lo_cnt = 0;
    logic sclk_bad = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (!lcd_rstn) begin
                rst_low = rst_low + 1;
                if (!lcd_csn) rst_cs_bad = 1'b1;
            end else if (rst_low != 0) begin
                rst_low_max = rst_low;
                rst_low = 0;
            end
            if (lcd_sclk) begin
                hi_cnt = hi_cnt + 1;
                if (lo_cnt != 0 && lo_cnt != SCK_HALF) sclk_bad = 1'b1;
                lo_cnt = 0;
            end else begin
                if (hi_cnt != 0 && hi_cnt != SCK_HALF) sclk_bad = 1'b1;
                hi_cnt = 0;
                if (nb != 0) lo_cnt = lo_cnt + 1;
            end
        end
    end

    always @(posedge lcd_sclk) begin
        sh = {sh[6:0], lcd_mosi};
        nb = nb + 1;
        if (nb == 8) begin
            if (ncap < 32) begin
                cap_b[ncap]  = sh;
                cap_dc[ncap] = lcd_dc;
                cap_cs[ncap] = lcd_csn;
                cap_t[ncap]  = cyc;
            end
            ncap = ncap + 1;
            nb = 0;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_cap();
        ncap = 0;
        nb = 0;
        sclk_bad = 1'b0;
    endtask

    // mask bits: 0 init, 1 wake, 2 sleep, 3 contrast
    task automatic pulse(input logic [3:0] mask, input logic [7:0] v);
        @(negedge clk);
        init_req     = mask[0];
        wake_req     = mask[1];
        sleep_req    = mask[2];
        contrast_req = mask[3];
        contrast_v   = v;
        @(negedge clk);
        init_req = 1'b0; wake_req = 1'b0; sleep_req = 1'b0; contrast_req = 1'b0;
    endtask

    task automatic run_op(input logic [3:0] mask, input logic [7:0] v);
        pulse(mask, v);
        chk(busy == 1'b1, "R9 busy after request", int'(busy), 1);
        while (!done) @(negedge clk);
        tfall = cyc;
        chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
        chk(lcd_csn == 1'b1, "R9 csn released", int'(lcd_csn), 1);
    endtask

    task automatic check_bytes(input string req, input int n, input logic [79:0] exp);
        chk(ncap == n, req, ncap, n);
        for (int i = 0; i < n && i < ncap; i++) begin
            chk(cap_b[i] == exp[79-8*i -: 8], req, int'(cap_b[i]), int'(exp[79-8*i -: 8]));
            chk(cap_dc[i] == 1'b0 && cap_cs[i] == 1'b0, "R2 command framing",
                int'({cap_dc[i], cap_cs[i]}), 0);
        end
        chk(sclk_bad == 1'b0, "R8 sclk phase length", int'(sclk_bad), 0);
    endtask

    // row: {mask[3:0], value[7:0], count[3:0], bytes[79:0]}
    localparam logic [95:0] VEC [6] = '{
        {4'b0001, 8'h00, 4'd10, 80'h21_06_13_C0_20_0C_20_0D_20_0C},
        {4'b0010, 8'h00, 4'd2,  80'h20_0C_00_00_00_00_00_00_00_00},
        {4'b0100, 8'h00, 4'd3,  80'h20_08_24_00_00_00_00_00_00_00},
        {4'b1000, 8'h00, 4'd2,  80'h21_80_00_00_00_00_00_00_00_00},
        {4'b1000, 8'hFF, 4'd2,  80'h21_FF_00_00_00_00_00_00_00_00},
        {4'b1000, 8'h5A, 4'd2,  80'h21_AD_00_00_00_00_00_00_00_00}
    };

    function automatic string tag(input logic [3:0] m);
        case (m)
            4'b0001: return "R2 init bytes";
            4'b0010: return "R5 wake bytes";
            4'b0100: return "R6 sleep bytes";
            default: return "R7 contrast bytes";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0, "R1 busy/done reset", int'({busy, done}), 0);
        chk(lcd_csn == 1 && lcd_rstn == 1, "R1 csn/rstn reset", int'({lcd_csn, lcd_rstn}), 3);
        chk(lcd_sclk == 0 && lcd_dc == 0, "R1 sclk/dc reset", int'({lcd_sclk, lcd_dc}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < 6; k++) begin
            clear_cap();
            run_op(VEC[k][95:92], VEC[k][91:84]);
            check_bytes(tag(VEC[k][95:92]), int'(VEC[k][83:80]), VEC[k][79:0]);
            if (k == 0) begin
                // R3 reset pulse
                chk(rst_low_max >= 18*CPM && rst_low_max <= 18*CPM + 2,
                    "R3 reset low length", rst_low_max, 18*CPM);
                chk(rst_cs_bad == 1'b0, "R3 csn high during reset", int'(rst_cs_bad), 0);
                // R4 init waits
                chk(cap_t[6] - cap_t[5] >= 100*CPM && cap_t[6] - cap_t[5] <= 100*CPM + 16*SCK_HALF + 8,
                    "R4 100ms after display on", cap_t[6] - cap_t[5], 100*CPM);
                chk(cap_t[8] - cap_t[7] >= 200*CPM && cap_t[8] - cap_t[7] <= 200*CPM + 16*SCK_HALF + 8,
                    "R4 200ms after inverse", cap_t[8] - cap_t[7], 200*CPM);
                chk(tfall - cap_t[9] >= 100*CPM && tfall - cap_t[9] <= 100*CPM + SCK_HALF + 10,
                    "R4 100ms before end", tfall - cap_t[9], 100*CPM);
            end
            if (k == 2) begin
                chk(tfall - cap_t[2] >= 50*CPM && tfall - cap_t[2] <= 50*CPM + SCK_HALF + 10,
                    "R6 50ms after power down", tfall - cap_t[2], 50*CPM);
            end
        end

        // R10: requests during a sleep run are ignored
        clear_cap();
        pulse(4'b0100, 8'h00);
        repeat (20) @(negedge clk);
        pulse(4'b1001, 8'h33);
        repeat (200) @(negedge clk);
        pulse(4'b0010, 8'h00);
        while (!done) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R10 no restart after ignored request", int'(busy), 0);
        check_bytes("R10 sleep stream unchanged", 3, 80'h20_08_24_00_00_00_00_00_00_00);

        // R11: sleep beats wake and contrast
        clear_cap();
        run_op(4'b1110, 8'h44);
        check_bytes("R11 sleep over wake/contrast", 3, 80'h20_08_24_00_00_00_00_00_00_00);
        // R11: wake beats contrast
        clear_cap();
        run_op(4'b1010, 8'h44);
        check_bytes("R11 wake over contrast", 2, 80'h20_0C_00_00_00_00_00_00_00_00);
        // R11: init beats all
        clear_cap();
        run_op(4'b1111, 8'h44);
        check_bytes("R11 init over all", 10, 80'h21_06_13_C0_20_0C_20_0D_20_0C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule